// File: doc/BRIEF.md
# I2C Register Transaction Sequencer with Retry

This block sequences complete I2C transactions on top of a bit-level bus engine. The engine performs the physical bus steps. The sequencer decides which step comes next, collects missing acknowledges into a three-bit error mask, and repeats a failed transaction from the start. It issues one engine command at a time (start, stop, byte write, acknowledge sample, byte read, send ACK, send NACK, idle wait) and waits for the engine's response before issuing the next one.

Four request kinds are supported:
- a single-register write;
- a single-register read that uses a repeated start;
- a burst write of up to `MAX_BYTES` bytes;
- a burst read of up to `MAX_BYTES` bytes.

The device address is given as an 8-bit field. Bit 0 of that field is replaced by the direction bit: 0 for write and 1 for read. Captured read bytes appear in a small buffer. Byte *i* sits at bits `[8*i+7:8*i]`. A transaction is attempted at most `ATTEMPTS` times. The default is 4.

Top module: `i2c_txn_seq`

## Requirements
- R1: A request of kind 0 (register write) issues, in order, these engine commands:
  - START;
  - WRITE of the address with bit 0 cleared, then GETACK;
  - WRITE of the register index, then GETACK;
  - WRITE of write-data byte 0, then GETACK;
  - STOP.

  Engine command codes are: 0 START, 1 STOP, 2 WRITE, 3 GETACK, 4 READ, 5 ACK, 6 NACK, 7 WAIT. A GETACK response with ack=1 means the byte was acknowledged.
- R2: A GETACK answered with ack=0 sets one bit of the error mask:
  - bit 0 for the write-direction address;
  - bit 0 for the burst-read address;
  - bit 1 for the register index;
  - bit 2 for any written data byte;
  - bit 2 for the read-direction address of a register read.
- R3: After STOP, if the mask is non-zero and fewer than `ATTEMPTS` attempts have run, the mask is cleared and the whole sequence restarts from START. The reported mask is the mask of the last attempt.
- R4: A request of kind 1 (register read) issues, in order:
  - START;
  - WRITE of the address with bit 0 cleared, then GETACK;
  - WRITE of the register index, then GETACK;
  - WAIT, then START;
  - WRITE of the address with bit 0 set, then GETACK;
  - READ, then NACK, then STOP.

  The byte read is placed in buffer entry 0.
- R5: A request of kind 3 (burst read) issues START, then WRITE of the address with bit 0 set, then GETACK. It then issues a READ for each byte. Every READ except the last is followed by ACK, and the last is followed by NACK. STOP comes last. The whole read buffer is zeroed at the start of every attempt.
- R6: A request of kind 2 (burst write) issues START, then WRITE of the address with bit 0 cleared, then GETACK. It then issues a WRITE and a GETACK for each byte, and finally STOP. All bytes are sent even after a data byte has been refused.
- R7: A burst request with a byte count of zero issues only START, the address WRITE, GETACK and STOP.
- R8: Write kinds (0 and 2) issue one WAIT after the final attempt's STOP and before done. Read kinds issue no command after the final STOP.
- R9: `done` is a one-cycle pulse two clock cycles after the edge at which the final engine response is taken. `err_mask` holds the final mask from that cycle onward. `busy` is high from the cycle after the request until `done`, and low at the same time as `done`. After reset, `busy`, `done`, `eng_cmd_valid` and `err_mask` are all zero.
- R10: A request presented while `busy` is high is ignored.
- R11: A byte count above `MAX_BYTES` is treated as `MAX_BYTES`.
- R12: A register read reports the byte captured in its last attempt even when the final mask is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a transaction (taken only while idle) |
| req_kind | input | 2 | 0 reg write, 1 reg read, 2 burst write, 3 burst read |
| req_dev | input | 8 | Device address field; bit 0 replaced by direction |
| req_reg | input | 8 | Register index |
| req_count | input | $clog2(MAX_BYTES+1) | Burst byte count |
| req_wdata | input | 8*MAX_BYTES | Write bytes, byte i at [8i+7:8i] |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| err_mask | output | 3 | Final error mask |
| rd_data | output | 8*MAX_BYTES | Read buffer, byte i at [8i+7:8i] |
| eng_cmd_valid | output | 1 | One-cycle engine command strobe |
| eng_cmd_op | output | 3 | Engine command code |
| eng_cmd_byte | output | 8 | Byte for WRITE commands |
| eng_rsp_valid | input | 1 | Engine finished the pending command |
| eng_rsp_ack | input | 1 | GETACK result, 1 = acknowledged |
| eng_rsp_byte | input | 8 | READ result |

## Verification
Each engine command is due on the clock after the response to the previous command is taken. The bench's engine model samples `eng_cmd_valid` at falling edges and answers a fixed three cycles later, logging every command and its byte for comparison against a sequence built from the requirements.

`done` is due exactly two clocks after the edge that takes the final response. The bench stamps the cycle at which it drives each response and the cycle at which it sees `done`, then checks that the difference is 2. It also checks that `done` is low one cycle later.

`busy` is checked at the first falling edge after the request. `rd_data` and `err_mask` are read at the `done` cycle. For an ignored request, the bench waits twenty further cycles and confirms that no engine command appeared.

// File: rtl/i2c_txn_pkg.sv
package i2c_txn_pkg;

  typedef enum logic [2:0] {
    OP_START  = 3'd0,
    OP_STOP   = 3'd1,
    OP_WRITE  = 3'd2,
    OP_GETACK = 3'd3,
    OP_READ   = 3'd4,
    OP_ACK    = 3'd5,
    OP_NACK   = 3'd6,
    OP_WAIT   = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    K_REG_WR   = 2'd0,
    K_REG_RD   = 2'd1,
    K_BURST_WR = 2'd2,
    K_BURST_RD = 2'd3
  } kind_e;

  typedef enum logic [4:0] {
    S_IDLE, S_START, S_ADDRW, S_ACK_ADDR, S_REG, S_ACK_REG,
    S_DATA, S_ACK_DATA, S_WAIT_RS, S_RSTART, S_ADDRR, S_ACK_ADDRR,
    S_RDBYTE, S_SENDACK, S_SENDNACK, S_STOP, S_CHECK, S_TAILWAIT, S_FIN
  } step_e;

endpackage

// File: rtl/i2c_txn_retry.sv
module i2c_txn_retry #(
  parameter int ATTEMPTS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic bump,
  output logic last
);
  localparam int AW = (ATTEMPTS > 1) ? $clog2(ATTEMPTS) : 1;

  logic [AW-1:0] att_q;

  always_ff @(posedge clk) begin
    if (rst || restart) att_q <= '0;
    else if (bump)      att_q <= att_q + AW'(1);
  end

  assign last = (att_q == AW'(ATTEMPTS - 1));

  // R3
  bump_guard_chk: assert property (@(posedge clk) disable iff (rst)
    bump |-> !last);
endmodule

// File: rtl/i2c_txn_rdbuf.sv
module i2c_txn_rdbuf #(
  parameter int MAX_BYTES = 4,
  parameter int IDX_W     = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clr,
  input  logic                   we,
  input  logic [IDX_W-1:0]       idx,
  input  logic [7:0]             wbyte,
  output logic [MAX_BYTES*8-1:0] rd_flat
);
  for (genvar i = 0; i < MAX_BYTES; i++) begin : g_ent
    logic [7:0] ent_q;
    always_ff @(posedge clk) begin
      if (rst || clr)                 ent_q <= 8'h00;
      else if (we && idx == IDX_W'(i)) ent_q <= wbyte;
    end
    assign rd_flat[i*8 +: 8] = ent_q;
  end

  // R5
  clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && !we) |=> (rd_flat == '0));
endmodule

// File: rtl/i2c_txn_ctrl.sv
module i2c_txn_ctrl
  import i2c_txn_pkg::*;
#(
  parameter int MAX_BYTES = 4,
  parameter int CNT_W     = 3,
  parameter int IDX_W     = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic [1:0]             req_kind,
  input  logic [7:0]             req_dev,
  input  logic [7:0]             req_reg,
  input  logic [CNT_W-1:0]       req_count,
  input  logic [MAX_BYTES*8-1:0] req_wdata,
  output logic                   busy,
  output logic                   done,
  output logic [2:0]             err_mask,
  output logic                   eng_cmd_valid,
  output logic [2:0]             eng_cmd_op,
  output logic [7:0]             eng_cmd_byte,
  input  logic                   eng_rsp_valid,
  input  logic                   eng_rsp_ack,
  input  logic                   att_last,
  output logic                   att_restart,
  output logic                   att_bump,
  output logic                   buf_clr,
  output logic                   buf_we,
  output logic [IDX_W-1:0]       buf_idx
);
  step_e                  st_q, nxt_st;
  kind_e                  kind_q;
  logic [7:0]             dev_q, reg_q;
  logic [MAX_BYTES*8-1:0] wdata_q;
  logic [CNT_W-1:0]       cnt_q, idx_q, cnt_sat;
  logic [2:0]             err_q, err_bit;
  logic                   pend_q, busy_q, done_q;
  logic [2:0]             mask_q;
  logic                   cmd_valid_q;
  op_e                    cmd_op_q, cur_op;
  logic [7:0]             cmd_byte_q, cur_byte;
  logic                   rsp_take, is_ack_st, retry_now, last_byte, idx_inc;

  assign cnt_sat = (req_count > CNT_W'(MAX_BYTES)) ? CNT_W'(MAX_BYTES) : req_count;
  assign rsp_take  = pend_q && eng_rsp_valid;
  assign last_byte = (kind_q == K_REG_WR) || (kind_q == K_REG_RD) ||
                     (idx_q == cnt_q - CNT_W'(1));
  assign retry_now = (st_q == S_CHECK) && (err_q != 3'b000) && !att_last;

  // command for the current step
  always_comb begin
    cur_op   = OP_WAIT;
    cur_byte = 8'h00;
    case (st_q)
      S_START, S_RSTART: cur_op = OP_START;
      S_ADDRW: begin cur_op = OP_WRITE; cur_byte = {dev_q[7:1], 1'b0}; end
      S_ADDRR: begin cur_op = OP_WRITE; cur_byte = {dev_q[7:1], 1'b1}; end
      S_REG:   begin cur_op = OP_WRITE; cur_byte = reg_q; end
      S_DATA:  begin cur_op = OP_WRITE; cur_byte = wdata_q[idx_q*8 +: 8]; end
      S_ACK_ADDR, S_ACK_REG, S_ACK_DATA, S_ACK_ADDRR: cur_op = OP_GETACK;
      S_RDBYTE:   cur_op = OP_READ;
      S_SENDACK:  cur_op = OP_ACK;
      S_SENDNACK: cur_op = OP_NACK;
      S_STOP:     cur_op = OP_STOP;
      default:    cur_op = OP_WAIT;
    endcase
  end

  // step that follows the current one once the engine has answered
  always_comb begin
    nxt_st    = st_q;
    err_bit   = 3'b000;
    is_ack_st = 1'b0;
    idx_inc   = 1'b0;
    case (st_q)
      S_START:    nxt_st = (kind_q == K_BURST_RD) ? S_ADDRR : S_ADDRW;
      S_ADDRW:    nxt_st = S_ACK_ADDR;
      S_ACK_ADDR: begin
        is_ack_st = 1'b1;
        err_bit   = 3'b001;
        if (kind_q == K_BURST_WR) nxt_st = (cnt_q == '0) ? S_STOP : S_DATA;
        else                      nxt_st = S_REG;
      end
      S_REG:      nxt_st = S_ACK_REG;
      S_ACK_REG: begin
        is_ack_st = 1'b1;
        err_bit   = 3'b010;
        nxt_st    = (kind_q == K_REG_RD) ? S_WAIT_RS : S_DATA;
      end
      S_DATA:     nxt_st = S_ACK_DATA;
      S_ACK_DATA: begin
        is_ack_st = 1'b1;
        err_bit   = 3'b100;
        idx_inc   = 1'b1;
        nxt_st    = last_byte ? S_STOP : S_DATA;
      end
      S_WAIT_RS:  nxt_st = S_RSTART;
      S_RSTART:   nxt_st = S_ADDRR;
      S_ADDRR:    nxt_st = S_ACK_ADDRR;
      S_ACK_ADDRR: begin
        is_ack_st = 1'b1;
        err_bit   = (kind_q == K_REG_RD) ? 3'b100 : 3'b001;
        nxt_st    = (kind_q == K_BURST_RD && cnt_q == '0) ? S_STOP : S_RDBYTE;
      end
      S_RDBYTE: begin
        idx_inc = 1'b1;
        nxt_st  = last_byte ? S_SENDNACK : S_SENDACK;
      end
      S_SENDACK:  nxt_st = S_RDBYTE;
      S_SENDNACK: nxt_st = S_STOP;
      S_STOP:     nxt_st = S_CHECK;
      S_TAILWAIT: nxt_st = S_FIN;
      default:    nxt_st = st_q;
    endcase
  end

  assign att_restart = (st_q == S_IDLE) && req_valid;
  assign att_bump    = retry_now;
  assign buf_clr     = ((st_q == S_IDLE) && req_valid && req_kind[0]) ||
                       (retry_now && kind_q[0]);
  assign buf_we      = rsp_take && (st_q == S_RDBYTE);
  assign buf_idx     = idx_q[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= S_IDLE;
      kind_q      <= K_REG_WR;
      dev_q       <= 8'h00;
      reg_q       <= 8'h00;
      wdata_q     <= '0;
      cnt_q       <= '0;
      idx_q       <= '0;
      err_q       <= 3'b000;
      mask_q      <= 3'b000;
      pend_q      <= 1'b0;
      busy_q      <= 1'b0;
      done_q      <= 1'b0;
      cmd_valid_q <= 1'b0;
      cmd_op_q    <= OP_START;
      cmd_byte_q  <= 8'h00;
    end else begin
      cmd_valid_q <= 1'b0;
      done_q      <= 1'b0;
      case (st_q)
        S_IDLE: begin
          if (req_valid) begin
            kind_q  <= kind_e'(req_kind);
            dev_q   <= req_dev;
            reg_q   <= req_reg;
            wdata_q <= req_wdata;
            cnt_q   <= cnt_sat;
            idx_q   <= '0;
            err_q   <= 3'b000;
            busy_q  <= 1'b1;
            st_q    <= S_START;
          end
        end
        S_CHECK: begin
          if (retry_now) begin
            err_q <= 3'b000;
            idx_q <= '0;
            st_q  <= S_START;
          end else if (!kind_q[0]) begin
            st_q <= S_TAILWAIT;
          end else begin
            done_q <= 1'b1;
            busy_q <= 1'b0;
            mask_q <= err_q;
            st_q   <= S_IDLE;
          end
        end
        S_FIN: begin
          done_q <= 1'b1;
          busy_q <= 1'b0;
          mask_q <= err_q;
          st_q   <= S_IDLE;
        end
        default: begin
          if (!pend_q) begin
            cmd_valid_q <= 1'b1;
            cmd_op_q    <= cur_op;
            cmd_byte_q  <= cur_byte;
            pend_q      <= 1'b1;
          end else if (eng_rsp_valid) begin
            pend_q <= 1'b0;
            st_q   <= nxt_st;
            if (is_ack_st && !eng_rsp_ack) err_q <= err_q | err_bit;
            if (idx_inc) idx_q <= idx_q + CNT_W'(1);
          end
        end
      endcase
    end
  end

  assign busy          = busy_q;
  assign done          = done_q;
  assign err_mask      = mask_q;
  assign eng_cmd_valid = cmd_valid_q;
  assign eng_cmd_op    = cmd_op_q;
  assign eng_cmd_byte  = cmd_byte_q;

  // R10
  req_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && req_valid) |=> ($stable(kind_q) && $stable(dev_q) && $stable(cnt_q)));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !busy_q);
  // R1
  cmd_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    eng_cmd_valid |=> !eng_cmd_valid);
  // R11
  cnt_cap_chk: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (cnt_q <= CNT_W'(MAX_BYTES)));
endmodule

// File: rtl/i2c_txn_seq.sv
module i2c_txn_seq #(
  parameter int MAX_BYTES = 4,
  parameter int ATTEMPTS  = 4
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             req_valid,
  input  logic [1:0]                       req_kind,
  input  logic [7:0]                       req_dev,
  input  logic [7:0]                       req_reg,
  input  logic [$clog2(MAX_BYTES+1)-1:0]   req_count,
  input  logic [MAX_BYTES*8-1:0]           req_wdata,
  output logic                             busy,
  output logic                             done,
  output logic [2:0]                       err_mask,
  output logic [MAX_BYTES*8-1:0]           rd_data,
  output logic                             eng_cmd_valid,
  output logic [2:0]                       eng_cmd_op,
  output logic [7:0]                       eng_cmd_byte,
  input  logic                             eng_rsp_valid,
  input  logic                             eng_rsp_ack,
  input  logic [7:0]                       eng_rsp_byte
);
  localparam int CNT_W = $clog2(MAX_BYTES + 1);
  localparam int IDX_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;

  logic             att_last, att_restart, att_bump;
  logic             buf_clr, buf_we;
  logic [IDX_W-1:0] buf_idx;

  i2c_txn_ctrl #(.MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_kind(req_kind), .req_dev(req_dev),
    .req_reg(req_reg), .req_count(req_count), .req_wdata(req_wdata),
    .busy(busy), .done(done), .err_mask(err_mask),
    .eng_cmd_valid(eng_cmd_valid), .eng_cmd_op(eng_cmd_op), .eng_cmd_byte(eng_cmd_byte),
    .eng_rsp_valid(eng_rsp_valid), .eng_rsp_ack(eng_rsp_ack),
    .att_last(att_last), .att_restart(att_restart), .att_bump(att_bump),
    .buf_clr(buf_clr), .buf_we(buf_we), .buf_idx(buf_idx)
  );

  i2c_txn_retry #(.ATTEMPTS(ATTEMPTS)) u_retry (
    .clk(clk), .rst(rst), .restart(att_restart), .bump(att_bump), .last(att_last)
  );

  i2c_txn_rdbuf #(.MAX_BYTES(MAX_BYTES), .IDX_W(IDX_W)) u_rdbuf (
    .clk(clk), .rst(rst), .clr(buf_clr), .we(buf_we), .idx(buf_idx),
    .wbyte(eng_rsp_byte), .rd_flat(rd_data)
  );
endmodule

// File: tb/test_i2c_txn_seq.sv
module test_i2c_txn_seq;
  localparam int CLK_PERIOD = 10;
  localparam int MAXB = 4;
  localparam int LAT  = 3;
  localparam int O_START = 0, O_STOP = 1, O_WR = 2, O_GA = 3,
                 O_RD = 4, O_ACK = 5, O_NACK = 6, O_WAIT = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [1:0] req_kind = 2'd0;
  logic [7:0] req_dev = 8'h00, req_reg = 8'h00;
  logic [2:0] req_count = 3'd0;
  logic [31:0] req_wdata = 32'h0;
  logic busy, done, eng_cmd_valid;
  logic [2:0] err_mask, eng_cmd_op;
  logic [31:0] rd_data;
  logic [7:0] eng_cmd_byte;
  logic eng_rsp_valid = 1'b0, eng_rsp_ack = 1'b1;
  logic [7:0] eng_rsp_byte = 8'h00;

  i2c_txn_seq #(.MAX_BYTES(MAXB), .ATTEMPTS(4)) i_i2c_txn_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_dev(req_dev), .req_reg(req_reg), .req_count(req_count),
    .req_wdata(req_wdata), .busy(busy), .done(done), .err_mask(err_mask),
    .rd_data(rd_data), .eng_cmd_valid(eng_cmd_valid), .eng_cmd_op(eng_cmd_op),
    .eng_cmd_byte(eng_cmd_byte), .eng_rsp_valid(eng_rsp_valid),
    .eng_rsp_ack(eng_rsp_ack), .eng_rsp_byte(eng_rsp_byte)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  int log_op[1024];
  int log_b[1024];
  int log_n = 0;
  int last_rsp_cyc = 0;
  int nack_used = 0, nack_until = 0;
  logic [7:0] nack_byte = 8'h00;
  int rd_cnt = 0, rd_mark = 0;
  logic [7:0] rd_base = 8'h00;
  logic [7:0] last_wr = 8'h00;

  // engine model: answers each command LAT cycles after seeing it
  always begin
    @(negedge clk);
    if (!rst && eng_cmd_valid) begin
      automatic int op = int'(eng_cmd_op);
      automatic logic [7:0] b = eng_cmd_byte;
      automatic logic ack = 1'b1;
      log_op[log_n] = op;
      log_b[log_n]  = (op == O_WR) ? int'(b) : 0;
      log_n = log_n + 1;
      if (op == O_WR) last_wr = b;
      if (op == O_GA && last_wr == nack_byte && nack_used < nack_until) begin
        ack = 1'b0;
        nack_used = nack_used + 1;
      end
      repeat (LAT) @(negedge clk);
      eng_rsp_valid = 1'b1;
      eng_rsp_ack   = ack;
      eng_rsp_byte  = rd_base + 8'(rd_cnt - rd_mark);
      if (op == O_RD) rd_cnt = rd_cnt + 1;
      last_rsp_cyc  = cyc;
      @(negedge clk);
      eng_rsp_valid = 1'b0;
    end
  end

  int exp_op[256];
  int exp_b[256];
  int exp_n = 0;
  int log_base = 0;
  logic [2:0] got_err;
  logic [31:0] got_rd;
  int got_lat;
  logic got_done_after;

  task automatic chk(input logic ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic e(input int op, input int b);
    exp_op[exp_n] = op;
    exp_b[exp_n]  = b;
    exp_n++;
  endtask

  task automatic att_regwr(input int dev, input int rg, input int d);
    e(O_START, 0); e(O_WR, dev & 8'hFE); e(O_GA, 0); e(O_WR, rg); e(O_GA, 0);
    e(O_WR, d); e(O_GA, 0); e(O_STOP, 0);
  endtask

  task automatic att_regrd(input int dev, input int rg);
    e(O_START, 0); e(O_WR, dev & 8'hFE); e(O_GA, 0); e(O_WR, rg); e(O_GA, 0);
    e(O_WAIT, 0); e(O_START, 0); e(O_WR, dev | 1); e(O_GA, 0);
    e(O_RD, 0); e(O_NACK, 0); e(O_STOP, 0);
  endtask

  task automatic att_bw(input int dev, input int n, input logic [31:0] wd);
    e(O_START, 0); e(O_WR, dev & 8'hFE); e(O_GA, 0);
    for (int i = 0; i < n; i++) begin
      e(O_WR, int'(wd[i*8 +: 8])); e(O_GA, 0);
    end
    e(O_STOP, 0);
  endtask

  task automatic att_br(input int dev, input int n);
    e(O_START, 0); e(O_WR, dev | 1); e(O_GA, 0);
    for (int i = 0; i < n; i++) begin
      e(O_RD, 0);
      e((i == n - 1) ? O_NACK : O_ACK, 0);
    end
    e(O_STOP, 0);
  endtask

  task automatic set_nack(input logic [7:0] b, input int times);
    nack_byte  = b;
    nack_until = nack_used + times;
  endtask

  task automatic run(input int kind, input int dev, input int rg, input int cnt,
                     input logic [31:0] wd, input logic inject);
    int t;
    log_base = log_n;
    rd_mark  = rd_cnt;
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'(kind); req_dev = 8'(dev); req_reg = 8'(rg);
    req_count = 3'(cnt); req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R9 busy after request", int'(busy), 1);
    t = 0;
    while (!done && t < 5000) begin
      @(negedge clk);
      t++;
      if (inject && t == 5) begin
        req_valid = 1'b1; req_kind = 2'd2; req_count = 3'd0; req_dev = 8'h7E;
      end else begin
        req_valid = 1'b0;
      end
    end
    req_valid = 1'b0;
    chk(t < 5000, "R9 done watchdog", t, 0);
    chk(busy == 1'b0, "R9 busy low with done", int'(busy), 0);
    got_err = err_mask;
    got_rd  = rd_data;
    got_lat = cyc - last_rsp_cyc;
    chk(got_lat == 2, "R9 done latency", got_lat, 2);
    @(negedge clk);
    got_done_after = done;
    chk(got_done_after == 1'b0, "R9 done single pulse", int'(done), 0);
  endtask

  task automatic cmp_seq(input string tag);
    int n;
    logic ok;
    int bad;
    n = log_n - log_base;
    ok = (n == exp_n);
    bad = -1;
    if (ok) begin
      for (int i = 0; i < exp_n; i++) begin
        if (bad < 0 && (log_op[log_base+i] != exp_op[i] || log_b[log_base+i] != exp_b[i]))
          bad = i;
      end
      ok = (bad < 0);
    end
    if (!ok && bad >= 0)
      chk(1'b0, {tag, " command"}, log_op[log_base+bad]*256 + log_b[log_base+bad],
          exp_op[bad]*256 + exp_b[bad]);
    else
      chk(ok, {tag, " command count"}, n, exp_n);
    exp_n = 0;
  endtask

  task automatic t_reset;
    chk(busy == 0 && done == 0 && eng_cmd_valid == 0 && err_mask == 0,
        "R9 reset state", {busy, done, eng_cmd_valid, err_mask}, 0);
  endtask

  task automatic t_reg_write;
    set_nack(8'h00, 0);
    run(0, 8'hA3, 8'h10, 0, 32'h0000_005C, 1'b0);
    att_regwr(8'hA3, 8'h10, 8'h5C); e(O_WAIT, 0);
    cmp_seq("R1 R8 reg write");
    chk(got_err == 3'b000, "R1 reg write err", got_err, 0);
  endtask

  task automatic t_reg_write_retry;
    set_nack(8'h5C, 1);
    run(0, 8'hA2, 8'h10, 0, 32'h0000_005C, 1'b0);
    att_regwr(8'hA2, 8'h10, 8'h5C); att_regwr(8'hA2, 8'h10, 8'h5C); e(O_WAIT, 0);
    cmp_seq("R3 one retry");
    chk(got_err == 3'b000, "R3 mask after recovered retry", got_err, 0);
  endtask

  task automatic t_reg_nack_persist;
    set_nack(8'h10, 255);
    run(0, 8'hA2, 8'h10, 0, 32'h0000_005C, 1'b0);
    for (int a = 0; a < 4; a++) att_regwr(8'hA2, 8'h10, 8'h5C);
    e(O_WAIT, 0);
    cmp_seq("R3 four attempts");
    chk(got_err == 3'b010, "R2 register index bit1", got_err, 2);
  endtask

  task automatic t_bw_addr_nack;
    set_nack(8'h40, 255);
    run(2, 8'h40, 0, 3, 32'h0033_2211, 1'b0);
    for (int a = 0; a < 4; a++) att_bw(8'h40, 3, 32'h0033_2211);
    e(O_WAIT, 0);
    cmp_seq("R6 burst write addr refused");
    chk(got_err == 3'b001, "R2 address bit0", got_err, 1);
  endtask

  task automatic t_bw_data_nack;
    set_nack(8'h22, 1);
    run(2, 8'h41, 0, 3, 32'h0033_2211, 1'b0);
    att_bw(8'h40, 3, 32'h0033_2211); att_bw(8'h40, 3, 32'h0033_2211); e(O_WAIT, 0);
    cmp_seq("R6 burst write continues after data refusal");
    chk(got_err == 3'b000, "R6 burst write final mask", got_err, 0);
  endtask

  task automatic t_reg_read;
    int n0;
    set_nack(8'h00, 0);
    rd_base = 8'h91;
    run(1, 8'h51, 8'h22, 0, 32'h0, 1'b1);
    att_regrd(8'h51, 8'h22);
    cmp_seq("R4 R8 R10 reg read");
    chk(got_err == 3'b000, "R4 reg read err", got_err, 0);
    chk(got_rd[7:0] == 8'h91, "R4 reg read byte", got_rd[7:0], 8'h91);
    n0 = log_n;
    repeat (20) @(negedge clk);
    chk(log_n == n0 && busy == 1'b0, "R10 request during busy ignored", log_n - n0, 0);
  endtask

  task automatic t_reg_read_err;
    set_nack(8'h51, 255);
    rd_base = 8'hC0;
    run(1, 8'h50, 8'h22, 0, 32'h0, 1'b0);
    for (int a = 0; a < 4; a++) att_regrd(8'h50, 8'h22);
    cmp_seq("R3 reg read retries");
    chk(got_err == 3'b100, "R2 read address bit2", got_err, 4);
    chk(got_rd[7:0] == 8'hC3, "R12 last captured byte", got_rd[7:0], 8'hC3);
  endtask

  task automatic t_burst_read;
    set_nack(8'h00, 0);
    rd_base = 8'h40;
    run(3, 8'h60, 0, 4, 32'h0, 1'b0);
    att_br(8'h60, 4);
    cmp_seq("R5 burst read four");
    chk(got_rd == 32'h4342_4140, "R5 burst read data", got_rd, 32'h4342_4140);
    set_nack(8'h61, 1);
    rd_base = 8'h70;
    run(3, 8'h61, 0, 2, 32'h0, 1'b0);
    att_br(8'h60, 2); att_br(8'h60, 2);
    cmp_seq("R5 burst read retry");
    chk(got_rd == 32'h0000_7372, "R5 buffer cleared per attempt", got_rd, 32'h0000_7372);
    chk(got_err == 3'b000, "R5 burst read retry mask", got_err, 0);
  endtask

  task automatic t_zero;
    set_nack(8'h00, 0);
    run(2, 8'h30, 0, 0, 32'h0, 1'b0);
    att_bw(8'h30, 0, 32'h0); e(O_WAIT, 0);
    cmp_seq("R7 zero-count burst write");
    run(3, 8'h30, 0, 0, 32'h0, 1'b0);
    att_br(8'h30, 0);
    cmp_seq("R7 R8 zero-count burst read");
    chk(got_rd == 32'h0, "R7 zero-count read buffer", got_rd, 0);
  endtask

  task automatic t_sat;
    set_nack(8'h00, 0);
    rd_base = 8'h80;
    run(3, 8'h22, 0, 7, 32'h0, 1'b0);
    att_br(8'h22, 4);
    cmp_seq("R11 count saturates");
    chk(got_rd == 32'h8382_8180, "R11 saturated read data", got_rd, 32'h8382_8180);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_reg_write();
    t_reg_write_retry();
    t_reg_nack_persist();
    t_bw_addr_nack();
    t_bw_data_nack();
    t_reg_read();
    t_reg_read_err();
    t_burst_read();
    t_zero();
    t_sat();
    summary();
    $finish;
  end
endmodule